// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. Once reset is released it drives the memory's command, address, bank, clock-enable and data-mask pins through a fixed start-up order:
- a long quiet period of no-operation commands with clock enable and every mask bit held high;
- a precharge that closes every bank;
- a configurable number of auto refreshes, each followed by its recovery gap;
- a single mode register write whose contents come from parameters.

The refreshes and the mode write can be placed in either order through a parameter. Every wait is a parameter in clocks, and the quiet period is derived from the clock frequency in MHz times the required microseconds.

When the last wait has run out, `init_done` rises and stays high until the next reset. A system places this block in front of the normal memory scheduler. The scheduler's pin drive is multiplexed in once `init_done` is high. Reset may be applied at any time and restarts the whole sequence.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, and for STABLE_CYC = CLK_MHZ*STABLE_US cycles after it is released, the pins carry a no-operation command. A no-operation is {cs_n,ras_n,cas_n,we_n} = 0111 with addr and ba zero. Throughout the whole sequence cke is 1 and every dqm bit is 1.
- R2: In the interval after rising edge number STABLE_CYC (counted from the first edge with reset released), a precharge-all is driven for one cycle. A precharge-all is command 0010 with addr bit 10 set, all other addr bits zero, and ba zero.
- R3: The precharge is followed by exactly TRP_CYC no-operation cycles before the next command.
- R4: Exactly REFRESH_COUNT auto refreshes are issued (command 0001, addr and ba zero), each for one cycle and each followed by exactly TRC_CYC no-operation cycles.
- R5: One mode register write (command 0000) is issued, followed by exactly TMRD_CYC no-operation cycles. With MRS_FIRST=0 it comes after the last refresh gap; with MRS_FIRST=1 it comes right after the precharge gap and the refreshes follow it.
- R6: The mode write carries these fields:
  - addr[2:0]: burst length code, with 1→000, 2→001, 4→010, 8→011 and full page (BURST_LEN=0)→111;
  - addr[3]: burst type, 1 = interleaved;
  - addr[6:4]: read latency code, with 2→010 and 3→011;
  - addr[9]: write mode, 1 = burst reads with single-location writes;
  - addr[8:7], every addr bit from 10 up, and ba: all zero.
- R7: init_done is 0 until the interval that follows the last wait of the sequence. From that interval on it is 1, and the pins stay at no-operation until reset.
- R8: Asserting reset at any point, including after init_done, returns all pins and init_done to the R1 reset state. The full sequence then restarts from the beginning on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Multiplexed address / mode word |
| dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | High once initialization has completed |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of a recovery gap or a refresh loop. The sequencer must then forget its refresh count and its timer, and rebuild the full timeline from zero. The stimulus releases reset and then re-asserts it at a cycle drawn at random from the whole schedule, and also after completion. Two instances with different refresh counts, orders and mode fields run side by side, so a stale counter in either ordering shows up as a shifted command.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_STABLE   = 3'd0,
    ST_PRE      = 3'd1,
    ST_PRE_WAIT = 3'd2,
    ST_REF      = 3'd3,
    ST_REF_WAIT = 3'd4,
    ST_MRS      = 3'd5,
    ST_MRS_WAIT = 3'd6,
    ST_DONE     = 3'd7
  } init_step_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP  = 4'b0111;
  localparam sdram_cmd_t CMD_PRE  = 4'b0010;
  localparam sdram_cmd_t CMD_REF  = 4'b0001;
  localparam sdram_cmd_t CMD_MODE = 4'b0000;

  localparam int unsigned AUTO_PRE_BIT = 10;

  // Burst length encoding; 0 stands for full page
  function automatic logic [2:0] burst_len_code(input int unsigned len);
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // Read latency encoding; only 2 and 3 are legal
  function automatic logic [2:0] latency_code(input int unsigned lat);
    return (lat == 2) ? 3'b010 : 3'b011;
  endfunction

  // Full 16-bit mode word; reserved and test bits stay zero
  function automatic logic [15:0] build_mode_word(input int unsigned len,
                                                  input bit interleave,
                                                  input int unsigned lat,
                                                  input bit single_wr);
    logic [15:0] w;
    w      = '0;
    w[2:0] = burst_len_code(len);
    w[3]   = interleave;
    w[6:4] = latency_code(lat);
    w[9]   = single_wr;
    return w;
  endfunction

  // Command placed on the pins while a step is active
  function automatic sdram_cmd_t step_cmd(input init_step_t s);
    case (s)
      ST_PRE:  return CMD_PRE;
      ST_REF:  return CMD_REF;
      ST_MRS:  return CMD_MODE;
      default: return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] span,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = run && (cnt_q == span - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && !last) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int unsigned ADDR_W           = 12,
  parameter int unsigned BURST_LEN        = 4,
  parameter bit          BURST_INTERLEAVE = 1'b0,
  parameter int unsigned CAS_LAT          = 3,
  parameter bit          WRITE_SINGLE     = 1'b0
) (
  output logic [ADDR_W-1:0] word
);
  import sdram_init_pkg::*;

  localparam logic [15:0] FULL_WORD =
    build_mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LAT, WRITE_SINGLE);

  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < 16) begin : g_field
        assign word[i] = FULL_WORD[i];
      end else begin : g_zero
        assign word[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int unsigned CLK_MHZ          = 250,
  parameter int unsigned STABLE_US        = 200,
  parameter int unsigned TRP_CYC          = 3,
  parameter int unsigned TRC_CYC          = 9,
  parameter int unsigned TMRD_CYC         = 2,
  parameter int unsigned REFRESH_COUNT    = 2,
  parameter bit          MRS_FIRST        = 1'b0,
  parameter int unsigned BURST_LEN        = 4,
  parameter bit          BURST_INTERLEAVE = 1'b0,
  parameter int unsigned CAS_LAT          = 3,
  parameter bit          WRITE_SINGLE     = 1'b0,
  parameter int unsigned ADDR_W           = 12,
  parameter int unsigned BANK_W           = 2,
  parameter int unsigned DQM_W            = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);
  import sdram_init_pkg::*;

  localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int unsigned SPAN_A     = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int unsigned SPAN_B     = (SPAN_A > TMRD_CYC) ? SPAN_A : TMRD_CYC;
  localparam int unsigned MAX_SPAN   = (SPAN_B > STABLE_CYC) ? SPAN_B : STABLE_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_SPAN + 1);
  localparam int unsigned REF_W      = $clog2(REFRESH_COUNT + 1);

  init_step_t       state_q, state_d;
  logic [REF_W-1:0] ref_cnt_q;
  logic [CNT_W-1:0] step_span;
  logic             step_last;
  logic             step_advance;
  logic             refs_all_done;
  logic             timer_run;
  logic [ADDR_W-1:0] mode_word;
  sdram_cmd_t       cmd_q;

  // Length of the active step in clocks
  always_comb begin
    case (state_q)
      ST_STABLE:   step_span = CNT_W'(STABLE_CYC);
      ST_PRE_WAIT: step_span = CNT_W'(TRP_CYC);
      ST_REF_WAIT: step_span = CNT_W'(TRC_CYC);
      ST_MRS_WAIT: step_span = CNT_W'(TMRD_CYC);
      default:     step_span = CNT_W'(1);
    endcase
  end

  assign timer_run     = (state_q != ST_DONE);
  assign step_advance  = step_last && timer_run;
  assign refs_all_done = (ref_cnt_q == REF_W'(REFRESH_COUNT));

  init_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .restart (step_advance),
    .span    (step_span),
    .last    (step_last)
  );

  sdram_mode_word #(
    .ADDR_W           (ADDR_W),
    .BURST_LEN        (BURST_LEN),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_LAT          (CAS_LAT),
    .WRITE_SINGLE     (WRITE_SINGLE)
  ) u_mode (
    .word (mode_word)
  );

  // Step ordering; MRS_FIRST picks where the mode write sits
  always_comb begin
    state_d = state_q;
    if (step_advance) begin
      case (state_q)
        ST_STABLE:   state_d = ST_PRE;
        ST_PRE:      state_d = ST_PRE_WAIT;
        ST_PRE_WAIT: state_d = MRS_FIRST ? ST_MRS : ST_REF;
        ST_REF:      state_d = ST_REF_WAIT;
        ST_REF_WAIT: begin
          if (!refs_all_done)  state_d = ST_REF;
          else if (MRS_FIRST)  state_d = ST_DONE;
          else                 state_d = ST_MRS;
        end
        ST_MRS:      state_d = ST_MRS_WAIT;
        ST_MRS_WAIT: state_d = MRS_FIRST ? ST_REF : ST_DONE;
        default:     state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_STABLE;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (step_advance && state_q == ST_REF) begin
        ref_cnt_q <= ref_cnt_q + REF_W'(1);
      end
    end
  end

  // Registered pin drive, following the step being entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      addr      <= '0;
      ba        <= '0;
      cke       <= 1'b1;
      dqm       <= '1;
      init_done <= 1'b0;
    end else begin
      cmd_q     <= step_cmd(state_d);
      ba        <= '0;
      cke       <= 1'b1;
      dqm       <= '1;
      init_done <= (state_d == ST_DONE);
      if (state_d == ST_PRE) begin
        addr <= ADDR_W'(1) << AUTO_PRE_BIT;
      end else if (state_d == ST_MRS) begin
        addr <= mode_word;
      end else begin
        addr <= '0;
      end
    end
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DQM_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              init_done
);

  logic is_nop, is_pre, is_ref, is_mrs;
  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
  assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

  // R1: only the four start-up commands appear, with cke and masks high
  a_r1_legal_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nop || is_pre || is_ref || is_mrs) && cke && (&dqm));

  // R2: precharge closes all banks
  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[10] && (ba == '0));

  // R3: a gap follows the precharge
  a_r3_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> is_nop);

  // R4: a gap follows each refresh
  a_r4_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_nop);

  // R5: no command right after the mode write
  a_r5_mrs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |=> is_nop);

  // R6: reserved mode bits stay low
  a_r6_mrs_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr[8:7] == 2'b00) && ((addr >> 10) == '0) && (ba == '0));

  // R7: completion is sticky and leaves the pins idle
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .DQM_W  (DQM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .dqm       (dqm),
  .init_done (init_done)
);

// File: tb/tb_sdram_powerup_seq.sv
`timescale 1ns/1ps
module tb_sdram_powerup_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0]  a_ba, a_dqm;
  logic [11:0] a_addr;
  logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  b_ba, b_dqm;
  logic [11:0] b_addr;

  // Config A: refreshes then mode write
  localparam int A_STABLE = 250 * 4, A_TRP = 3, A_TRC = 9, A_TMRD = 2, A_NREF = 2;
  // Config B: mode write then refreshes
  localparam int B_STABLE = 100 * 3, B_TRP = 2, B_TRC = 7, B_TMRD = 3, B_NREF = 3;

  sdram_powerup_seq #(
    .CLK_MHZ(250), .STABLE_US(4), .TRP_CYC(A_TRP), .TRC_CYC(A_TRC),
    .TMRD_CYC(A_TMRD), .REFRESH_COUNT(A_NREF), .MRS_FIRST(1'b0),
    .BURST_LEN(4), .BURST_INTERLEAVE(1'b0), .CAS_LAT(3), .WRITE_SINGLE(1'b0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
    .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .dqm(a_dqm),
    .init_done(a_done)
  );

  sdram_powerup_seq #(
    .CLK_MHZ(100), .STABLE_US(3), .TRP_CYC(B_TRP), .TRC_CYC(B_TRC),
    .TMRD_CYC(B_TMRD), .REFRESH_COUNT(B_NREF), .MRS_FIRST(1'b1),
    .BURST_LEN(0), .BURST_INTERLEAVE(1'b1), .CAS_LAT(2), .WRITE_SINGLE(1'b1)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
    .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .dqm(b_dqm),
    .init_done(b_done)
  );

  int  tests = 0;
  int  fails = 0;
  int  n = 0;
  bit  finished = 0;

  // Step kinds: 0 quiet, 1 precharge, 2 precharge gap, 3 refresh,
  // 4 refresh gap, 5 mode write, 6 mode gap, 7 done
  function automatic int exp_kind(int cyc, int stable, int trp, int trc,
                                  int tmrd, int nref, bit mrs_first);
    int t;
    if (cyc < stable) return 0;
    if (cyc == stable) return 1;
    t = stable + 1;
    if (cyc < t + trp) return 2;
    t = t + trp;
    for (int part = 0; part < 2; part++) begin
      if ((part == 0) == mrs_first) begin
        if (cyc == t) return 5;
        if (cyc <= t + tmrd) return 6;
        t = t + 1 + tmrd;
      end else begin
        for (int r = 0; r < nref; r++) begin
          if (cyc == t) return 3;
          if (cyc <= t + trc) return 4;
          t = t + 1 + trc;
        end
      end
    end
    return 7;
  endfunction

  function automatic int seq_len(int stable, int trp, int trc, int tmrd, int nref);
    return stable + 1 + trp + nref * (1 + trc) + 1 + tmrd;
  endfunction

  function automatic logic [11:0] exp_mode(int bl, int bt, int cl, int ws);
    int blc;
    blc = 0;
    if (bl == 0) blc = 7;
    else while ((1 << blc) < bl) blc++;
    return 12'(ws * 512 + ((cl == 2) ? 2 : 3) * 16 + bt * 8 + blc);
  endfunction

  task automatic chk(string tag, string who, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual 0x%0h expected 0x%0h", tag, who, n, act, exp);
    end
  endtask

  task automatic check_dut(string who, int kind, bit rphase, logic [3:0] cmd,
                           logic [11:0] ad, logic [1:0] b, logic ck,
                           logic [1:0] dq, logic dn, logic [11:0] mode);
    string tag;
    logic [3:0]  ecmd;
    logic [11:0] eaddr;
    case (kind)
      1: begin ecmd = 4'b0010; eaddr = 12'h400; tag = "R2"; end
      2: begin ecmd = 4'b0111; eaddr = 12'h000; tag = "R3"; end
      3: begin ecmd = 4'b0001; eaddr = 12'h000; tag = "R4"; end
      4: begin ecmd = 4'b0111; eaddr = 12'h000; tag = "R4"; end
      5: begin ecmd = 4'b0000; eaddr = mode;    tag = "R5"; end
      6: begin ecmd = 4'b0111; eaddr = 12'h000; tag = "R5"; end
      7: begin ecmd = 4'b0111; eaddr = 12'h000; tag = "R7"; end
      default: begin ecmd = 4'b0111; eaddr = 12'h000; tag = "R1"; end
    endcase
    if (rphase) tag = "R8";
    chk(tag, who, int'(cmd), int'(ecmd));
    chk((kind == 5) ? "R6" : tag, who, int'(ad), int'(eaddr));
    chk(rphase ? "R8" : "R1", who, int'({ck, dq, b}), int'({1'b1, 2'b11, 2'b00}));
    chk(rphase ? "R8" : "R7", who, int'(dn), (kind == 7) ? 1 : 0);
  endtask

  task automatic sample(bit rphase);
    int ka, kb;
    ka = rphase ? 0 : exp_kind(n, A_STABLE, A_TRP, A_TRC, A_TMRD, A_NREF, 1'b0);
    kb = rphase ? 0 : exp_kind(n, B_STABLE, B_TRP, B_TRC, B_TMRD, B_NREF, 1'b1);
    check_dut("dut", ka, rphase, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba,
              a_cke, a_dqm, a_done, exp_mode(4, 0, 3, 0));
    check_dut("dut_b", kb, rphase, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba,
              b_cke, b_dqm, b_done, exp_mode(0, 1, 2, 1));
  endtask

  initial begin
    int full;
    int stop;
    void'($urandom(32'd4711));
    full = seq_len(A_STABLE, A_TRP, A_TRC, A_TMRD, A_NREF);
    if (seq_len(B_STABLE, B_TRP, B_TRC, B_TMRD, B_NREF) > full)
      full = seq_len(B_STABLE, B_TRP, B_TRC, B_TMRD, B_NREF);
    repeat (3) @(negedge clk);
    sample(1'b1);                                  // R8 / R1 reset state
    for (int run = 0; run < 6; run++) begin
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      sample(1'b1);                                // R8: reset clears at once
      for (int h = 0; h < 1 + int'($urandom % 5); h++) begin
        @(negedge clk);
        sample(1'b1);
      end
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      #0.5;
      sample(1'b0);
      case (run)
        1, 4:    stop = 1 + int'($urandom % full);   // R8: abort mid-sequence
        3:       stop = B_STABLE + 1 + B_TRP + 2;     // R8: abort in mode gap of dut_b
        default: stop = full + 12;                    // full runs, R7 stickiness
      endcase
      for (int c = 0; c < stop; c++) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        sample(1'b0);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule